// File: doc/BRIEF.md
# Video timing slave extractor

This block recovers line and field timing for a video encoder that follows an external timing source. It runs in one of three modes, chosen by a 3-bit mode field. In the embedded mode it watches the 10-bit multiplexed pixel stream for four-word timing reference sequences and takes field, vertical-blank and horizontal-blank state from the last word of each. In the two pin-driven modes it takes a horizontal sync and a field-parity input. A falling edge of the horizontal sync starts a new line. A change of the field input starts a new frame only when the horizontal sync level at that moment matches the level the mode requires.

The outputs are an active-video flag and its inverse blank flag, the field parity, a one-cycle new-frame strobe, a line counter and a pixel counter. All state is captured on the rising clock edge that samples the input change. The counters and the frame strobe are registered. The blank and active flags are decoded from registered state and the current mode inputs. In the pin-driven modes, blanking comes either from an active-low blank input or from an internal table of the lines that are blanked for the chosen 525-line or 625-line standard.

Top module: `vid_slave_timing`

## Requirements
- R1: `mode_i` 3'b000 selects embedded-code timing, 3'b010 selects pin timing with low-qualified frame detect, 3'b110 selects pin timing with high-qualified frame detect. Any other value forces `blank_o`=1 and `active_o`=0, and both counters hold.
- R2: In embedded mode a timing word is a word preceded by 3FF, 000, 000. Its bit 9 is 1, bit 8 is F, bit 7 is V and bit 6 is H. Bits 5..2 carry the protection bits V^H, F^H, F^V and F^V^H. H=1 marks end of active video (EAV) and H=0 marks start of active video (SAV).
- R3: A timing word whose protection bits do not match is ignored. F, V and H state are kept and neither counter sees a line or frame event.
- R4: In embedded mode `field_o` is F, and `blank_o` is V OR H of the last accepted timing word. `active_o` is always the inverse of `blank_o`.
- R5: A new frame is a field change from 1 to 0: an accepted timing word with F=0 while F was 1, or a qualified falling FIELD input in the pin modes. It pulses `frame_o` for one cycle and sets `line_o` to 1.
- R6: In mode 010, a falling FIELD with HSYNC low is a new frame. A FIELD change with HSYNC high is not a new frame, although `field_o` still follows FIELD.
- R7: In mode 110, a falling FIELD with HSYNC high is a new frame. A FIELD change with HSYNC low is not a new frame.
- R8: `line_o` increments by 1 on every accepted EAV (embedded) or HSYNC falling edge (pin modes). A new frame takes precedence over a line event in the same cycle. The counter saturates at its maximum.
- R9: `pix_cnt_o` is 0 in the cycle after a line or frame event, then rises by 1 per clock and saturates at its maximum.
- R10: In pin modes with `blank_en_i`=0 and `std_625_i`=0, `blank_o` is 1 on lines 0..22 and 263..284 and 0 on other lines.
- R11: In pin modes with `blank_en_i`=0 and `std_625_i`=1, `blank_o` is 1 on lines 0..22 and 311..335 and 0 on other lines.
- R12: In pin modes with `blank_en_i`=1, `blank_o` is the inverse of `blank_ni` as sampled at the last rising clock edge.
- R13: During reset `line_o`=0, `pix_cnt_o`=0, `field_o`=0, `frame_o`=0 and `blank_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Timing mode select |
| std_625_i | input | 1 | 1 selects the 625-line blank table, 0 the 525-line table |
| blank_en_i | input | 1 | 1 uses the blank input in pin modes |
| pix_i | input | DW (10) | Multiplexed pixel stream carrying timing words |
| hsync_i | input | 1 | Horizontal sync, active low |
| field_i | input | 1 | Field parity input |
| blank_ni | input | 1 | External blank, active low |
| active_o | output | 1 | Active video flag |
| blank_o | output | 1 | Blank flag |
| field_o | output | 1 | Current field parity |
| frame_o | output | 1 | One-cycle new-frame strobe |
| line_o | output | LINE_W (10) | Line counter |
| pix_cnt_o | output | PIX_W (12) | Pixel counter within the line |

## Verification
The bench builds the block with its defaults: a 10-bit word, a 10-bit line counter and a 12-bit pixel counter. With these widths the full 625-line blank table can be walked edge by edge through HSYNC pulses. Saturation of the line counter at 1023 and of the pixel counter at 4095 each takes only a few thousand cycles. Corrupted protection bits, field changes under both HSYNC levels and the frame-over-line precedence all fall inside one short run.

// File: rtl/vst_pkg.sv
package vst_pkg;
  localparam logic [2:0] MODE_EMB    = 3'b000;
  localparam logic [2:0] MODE_PIN_LO = 3'b010;
  localparam logic [2:0] MODE_PIN_HI = 3'b110;

  typedef struct packed {
    logic line_ev;
    logic frame_ev;
  } tev_t;

  function automatic logic mode_is_pin(logic [2:0] m);
    return (m == MODE_PIN_LO) || (m == MODE_PIN_HI);
  endfunction

  function automatic logic mode_is_legal(logic [2:0] m);
    return (m == MODE_EMB) || mode_is_pin(m);
  endfunction
endpackage

// File: rtl/vst_trs_dec.sv
module vst_trs_dec
  import vst_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] word_i,
  output tev_t          ev_o,
  output logic          f_o,
  output logic          v_o,
  output logic          h_o
);
  localparam logic [DW-1:0] W_ONES = '1;
  localparam logic [DW-1:0] W_ZERO = '0;

  logic [DW-1:0] w1_q, w2_q, w3_q;
  logic f_q, v_q, h_q;
  logic hdr, xf, xv, xh, xy_ok;
  logic [3:0] prot, prot_exp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w1_q <= '0;
      w2_q <= '0;
      w3_q <= '0;
    end else begin
      w1_q <= word_i;
      w2_q <= w1_q;
      w3_q <= w2_q;
    end
  end

  always_comb begin
    hdr      = (w3_q == W_ONES) && (w2_q == W_ZERO) && (w1_q == W_ZERO);
    xf       = word_i[DW-2];
    xv       = word_i[DW-3];
    xh       = word_i[DW-4];
    prot     = word_i[DW-5:DW-8];
    prot_exp = {xv ^ xh, xf ^ xh, xf ^ xv, xf ^ xv ^ xh};
    xy_ok    = hdr && word_i[DW-1] && (prot == prot_exp);
    ev_o.line_ev  = xy_ok && xh;
    ev_o.frame_ev = xy_ok && f_q && !xf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_q <= 1'b0;
      v_q <= 1'b1;
      h_q <= 1'b1;
    end else if (xy_ok) begin
      f_q <= xf;
      v_q <= xv;
      h_q <= xh;
    end
  end

  assign f_o = f_q;
  assign v_o = v_q;
  assign h_o = h_q;
endmodule

// File: rtl/vst_pin_dec.sv
module vst_pin_dec
  import vst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic field_i,
  input  logic blank_ni,
  input  logic qual_hi_i,
  output tev_t ev_o,
  output logic field_o,
  output logic ext_blank_o
);
  logic hs_q, fld_q, blk_q;
  logic qual;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q  <= 1'b0;
      fld_q <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      hs_q  <= hsync_i;
      fld_q <= field_i;
      blk_q <= blank_ni;
    end
  end

  // frame edge is qualified by the hsync level seen with the field change
  always_comb begin
    qual          = qual_hi_i ? hsync_i : !hsync_i;
    ev_o.line_ev  = hs_q && !hsync_i;
    ev_o.frame_ev = fld_q && !field_i && qual;
  end

  assign field_o     = fld_q;
  assign ext_blank_o = !blk_q;
endmodule

// File: rtl/vst_cnt.sv
module vst_cnt
  import vst_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int PIX_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  tev_t              ev_i,
  output logic [LINE_W-1:0] line_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic              frame_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);
  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [PIX_W-1:0]  PIX_ONE  = PIX_W'(1);

  logic [LINE_W-1:0] line_q;
  logic [PIX_W-1:0]  pix_q;
  logic              frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      pix_q   <= '0;
      frame_q <= 1'b0;
    end else begin
      frame_q <= en_i && ev_i.frame_ev;
      if (en_i) begin
        if (ev_i.frame_ev) begin
          line_q <= LINE_ONE;
          pix_q  <= '0;
        end else if (ev_i.line_ev) begin
          if (line_q != LINE_MAX) line_q <= line_q + LINE_ONE;
          pix_q <= '0;
        end else if (pix_q != PIX_MAX) begin
          pix_q <= pix_q + PIX_ONE;
        end
      end
    end
  end

  assign line_o  = line_q;
  assign pix_o   = pix_q;
  assign frame_o = frame_q;
endmodule

// File: rtl/vst_vblank.sv
module vst_vblank #(
  parameter int LINE_W    = 10,
  parameter int HEAD_END  = 22,
  parameter int L525_BEG  = 263,
  parameter int L525_END  = 284,
  parameter int L625_BEG  = 311,
  parameter int L625_END  = 335
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic              std_625_i,
  output logic              vblank_o
);
  localparam logic [LINE_W-1:0] HEAD_L = LINE_W'(HEAD_END);
  localparam logic [LINE_W-1:0] B525_L = LINE_W'(L525_BEG);
  localparam logic [LINE_W-1:0] E525_L = LINE_W'(L525_END);
  localparam logic [LINE_W-1:0] B625_L = LINE_W'(L625_BEG);
  localparam logic [LINE_W-1:0] E625_L = LINE_W'(L625_END);

  logic head, tail;

  // line 0 means not yet aligned and is blanked with the head range
  always_comb begin
    head = line_i <= HEAD_L;
    tail = std_625_i ? (line_i >= B625_L && line_i <= E625_L)
                     : (line_i >= B525_L && line_i <= E525_L);
    vblank_o = head || tail;
  end
endmodule

// File: rtl/vid_slave_timing.sv
module vid_slave_timing
  import vst_pkg::*;
#(
  parameter int DW     = 10,
  parameter int LINE_W = 10,
  parameter int PIX_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              std_625_i,
  input  logic              blank_en_i,
  input  logic [DW-1:0]     pix_i,
  input  logic              hsync_i,
  input  logic              field_i,
  input  logic              blank_ni,
  output logic              active_o,
  output logic              blank_o,
  output logic              field_o,
  output logic              frame_o,
  output logic [LINE_W-1:0] line_o,
  output logic [PIX_W-1:0]  pix_cnt_o
);
  tev_t trs_ev, pin_ev, sel_ev;
  logic trs_f, trs_v, trs_h;
  logic pin_f, pin_blank, vblank;
  logic is_emb, is_pin, is_legal;

  assign is_emb   = mode_i == MODE_EMB;
  assign is_pin   = mode_is_pin(mode_i);
  assign is_legal = mode_is_legal(mode_i);

  vst_trs_dec #(.DW(DW)) u_trs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .word_i (pix_i),
    .ev_o   (trs_ev),
    .f_o    (trs_f),
    .v_o    (trs_v),
    .h_o    (trs_h)
  );

  vst_pin_dec u_pin (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hsync_i     (hsync_i),
    .field_i     (field_i),
    .blank_ni    (blank_ni),
    .qual_hi_i   (mode_i[2]),
    .ev_o        (pin_ev),
    .field_o     (pin_f),
    .ext_blank_o (pin_blank)
  );

  assign sel_ev = is_emb ? trs_ev : pin_ev;

  vst_cnt #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (is_legal),
    .ev_i    (sel_ev),
    .line_o  (line_o),
    .pix_o   (pix_cnt_o),
    .frame_o (frame_o)
  );

  vst_vblank #(.LINE_W(LINE_W)) u_vbl (
    .line_i    (line_o),
    .std_625_i (std_625_i),
    .vblank_o  (vblank)
  );

  always_comb begin
    if (is_emb)      blank_o = trs_v || trs_h;
    else if (is_pin) blank_o = blank_en_i ? pin_blank : vblank;
    else             blank_o = 1'b1;
  end

  assign active_o = !blank_o;
  assign field_o  = is_emb ? trs_f : pin_f;
endmodule

// File: rtl/vst_checker.sv
module vst_checker
  import vst_pkg::*;
#(
  parameter int LINE_W   = 10,
  parameter int PIX_W    = 12,
  parameter int HEAD_END = 22
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        mode_i,
  input logic              blank_en_i,
  input logic              active_o,
  input logic              blank_o,
  input logic              frame_o,
  input logic [LINE_W-1:0] line_o,
  input logic [PIX_W-1:0]  pix_cnt_o
);
  localparam logic [PIX_W-1:0]  PIX_MAX = '1;
  localparam logic [LINE_W-1:0] HEAD_L  = LINE_W'(HEAD_END);

  logic legal, pin;
  assign legal = mode_is_legal(mode_i);
  assign pin   = mode_is_pin(mode_i);

  p_illegal_blank_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal |-> (blank_o && !active_o));

  p_frame_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);

  p_frame_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> (line_o == LINE_W'(1)));

  p_line_mono_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_o |-> (line_o >= $past(line_o)));

  p_pix_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(legal) && pix_cnt_o != '0 && $past(pix_cnt_o) != PIX_MAX)
      |-> (pix_cnt_o == $past(pix_cnt_o) + PIX_W'(1)));

  p_auto_head_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin && !blank_en_i && line_o <= HEAD_L) |-> blank_o);
endmodule

bind vid_slave_timing vst_checker #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_vst_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .blank_en_i (blank_en_i),
  .active_o   (active_o),
  .blank_o    (blank_o),
  .frame_o    (frame_o),
  .line_o     (line_o),
  .pix_cnt_o  (pix_cnt_o)
);

// File: tb/vid_slave_timing_bench.sv
module vid_slave_timing_bench;
  localparam int DW = 10, LINE_W = 10, PIX_W = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] mode = 3'b000;
  logic std_625 = 1'b0, blank_en = 1'b0;
  logic [DW-1:0] pix = 10'h200;
  logic hsync = 1'b1, field = 1'b0, blank_n = 1'b1;
  logic active, blank, fld, frame;
  logic [LINE_W-1:0] line;
  logic [PIX_W-1:0] pcnt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vid_slave_timing u_vid_slave_timing (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .std_625_i(std_625),
    .blank_en_i(blank_en), .pix_i(pix), .hsync_i(hsync), .field_i(field),
    .blank_ni(blank_n), .active_o(active), .blank_o(blank), .field_o(fld),
    .frame_o(frame), .line_o(line), .pix_cnt_o(pcnt)
  );

  // {f, v, h, bad, exp_field, exp_blank, exp_frame, exp_line[3:0]}
  localparam logic [10:0] TBL [10] = '{
    11'b1110_110_0001, 11'b1100_110_0001, 11'b0110_011_0001,
    11'b0000_000_0001, 11'b1111_000_0001, 11'b0010_010_0010,
    11'b0000_000_0010, 11'b0011_000_0010, 11'b0010_010_0011,
    11'b0000_000_0011
  };

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic send_trs(logic f, logic v, logic h, logic bad);
    logic [DW-1:0] xy;
    xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h ^ bad, 2'b00};
    step(); pix = 10'h3FF;
    step(); pix = 10'h000;
    step(); pix = 10'h000;
    step(); pix = xy;
    step(); pix = 10'h200;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      step(); hsync = 1'b0;
      step(); hsync = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R13 reset state
    chk("R13 line", line, 0);
    chk("R13 pix", pcnt, 0);
    chk("R13 field", fld, 0);
    chk("R13 frame", frame, 0);
    chk("R13 blank", blank, 1);
    rst_ni = 1'b1;

    // R2 R3 R4 R5 R8 embedded code table
    foreach (TBL[i]) begin
      send_trs(TBL[i][10], TBL[i][9], TBL[i][8], TBL[i][7]);
      chk($sformatf("R2/R3/R4 field e%0d", i), fld, TBL[i][6]);
      chk($sformatf("R4 blank e%0d", i), blank, TBL[i][5]);
      chk($sformatf("R4 active e%0d", i), active, !TBL[i][5]);
      chk($sformatf("R5 frame e%0d", i), frame, TBL[i][4]);
      chk($sformatf("R8 line e%0d", i), line, TBL[i][3:0]);
    end

    // R9 pixel counter after EAV
    send_trs(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8 line eav", line, 4);
    chk("R9 pix zero", pcnt, 0);
    repeat (5) step();
    chk("R9 pix step", pcnt, 5);

    // R6 low-qualified pin mode
    step(); mode = 3'b010; field = 1'b1;
    step();
    chk("R6 field follows", fld, 1);
    chk("R6 no frame rise", frame, 0);
    field = 1'b0;
    step();
    step();
    chk("R6 unqualified frame", frame, 0);
    chk("R6 field low", fld, 0);
    chk("R6 line kept", line, 4);
    field = 1'b1;
    step(); hsync = 1'b0;
    step();
    chk("R8 hsync fall", line, 5);
    field = 1'b0;
    step();
    chk("R6 frame", frame, 1);
    chk("R5 line one", line, 1);
    chk("R9 pix frame", pcnt, 0);
    hsync = 1'b1;
    step();
    chk("R5 single pulse", frame, 0);
    chk("R10 line1 blank", blank, 1);

    // R10 525 table
    pulses(21); chk("R10 line22", blank, 1);
    pulses(1);  chk("R10 line23", blank, 0);
    pulses(239); chk("R10 line262 line", line, 262); chk("R10 line262", blank, 0);
    pulses(1);  chk("R10 line263", blank, 1);
    pulses(21); chk("R10 line284", blank, 1);
    pulses(1);  chk("R10 line285", blank, 0);

    // R12 external blank
    blank_en = 1'b1; blank_n = 1'b0;
    step(); step();
    chk("R12 ext blank", blank, 1);
    blank_n = 1'b1;
    step(); step();
    chk("R12 ext active", blank, 0);
    blank_en = 1'b0;

    // R7 high-qualified pin mode
    step(); mode = 3'b110; field = 1'b1;
    step(); hsync = 1'b0;
    step(); field = 1'b0;
    step();
    chk("R7 low hsync no frame", frame, 0);
    chk("R7 line kept", line, 286);
    hsync = 1'b1;
    step(); field = 1'b1;
    step(); field = 1'b0;
    step();
    chk("R7 frame", frame, 1);
    chk("R7 line one", line, 1);

    // R11 625 table
    std_625 = 1'b1;
    pulses(21); chk("R11 line22", blank, 1);
    pulses(1);  chk("R11 line23", blank, 0);
    pulses(287); chk("R11 line310", blank, 0);
    pulses(1);  chk("R11 line311", blank, 1);
    pulses(24); chk("R11 line335", blank, 1);
    pulses(1);  chk("R11 line336", blank, 0);

    // R1 unsupported mode
    step(); mode = 3'b001;
    step();
    chk("R1 blank", blank, 1);
    chk("R1 active", active, 0);
    begin
      int p0;
      p0 = pcnt;
      pulses(3);
      chk("R1 line held", line, 336);
      chk("R1 pix held", pcnt, p0);
    end
    mode = 3'b110;

    // R8 line saturation
    pulses(689);
    chk("R8 line saturate", line, 1023);

    // R9 pixel saturation
    repeat (4200) step();
    chk("R9 pix saturate", pcnt, 4095);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule